// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A prescaler divides the reference clock (nominally 32.768 kHz) down to one advance per second. The hours byte can hold either a 24-hour value or a 12-hour value with an AM/PM flag. The date rolls over at the true end of each month, and February gets 29 days in leap years.

A register-style write port loads any field. The write is accepted in the cycle it is presented. There is no back-pressure and no handshake. Every write to a real field restarts the sub-second count, so software can set the time and know that the next advance comes exactly one second later. A combinational read port returns any field at any time. Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. Address 7 is unused.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 in 24-hour mode, day of week 01, date 01, month 01 and year 00.
- R2: Seconds and minutes count in BCD from 00 to 59. The step from 59 goes to 00 and carries into the next field.
- R3: When hours bit 6 is 0, hours count from 00 to 23 in BCD, with bit 5 serving as the tens digit for 20 to 23. The step from 23 goes to 00 and carries into the day.
- R4: When hours bit 6 is 1, bits 4:0 hold 01 to 12 in BCD and bit 5 means PM. The step from 11 goes to 12 and toggles bit 5. The step from 12 goes to 01 and leaves bit 5 unchanged. Only the step from 11 PM to 12 AM carries into the day.
- R5: Day of week advances on every day carry and wraps from 07 to 01.
- R6: On a day carry the date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. Each such wrap carries into the month.
- R7: In month 02 the date wraps after 29 when the year value is divisible by 4 (00 counts as a leap year), and after 28 otherwise.
- R8: A month carry from 12 sets the month to 01 and increments the year. The year wraps from 99 to 00.
- R9: A write stores the data ANDed with the field's mask: seconds 0x7F, minutes 0x7F, hours 0x7F, day of week 0x07, date 0x3F, month 0x1F, year 0xFF. Bits outside the mask always read 0. Address 7 reads 0 and writes to it change nothing, including the sub-second count.
- R10: A write to any of addresses 0 to 6 restarts the sub-second count. The next advance occurs exactly TICKS_PER_SEC reference cycles after the write edge.
- R11: Between advances no field changes unless it is written. Without writes, advances come every TICKS_PER_SEC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle per prescaler count |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted in the same cycle |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | BCD data to write |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Contents of the addressed field (combinational) |

## Verification
The range assertions assume that every value written is a legal BCD value for its field. They also assume that the date written fits the month and year in force once all writes of a set are complete. For that reason the date check is only applied on advance cycles, and writes suppress advances. The random stimulus builds each time from legal ranges, with the date limited to the month's length. Garbage is placed only in the masked-off bits, which the write masking removes. Boundary values such as 59 seconds, 23 or 11 hours and the last date of the month are favoured so that carries happen often.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int ADDR_W     = 3;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_DOW  = 3;
  localparam int I_DATE = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      I_SEC, I_MIN, I_HOUR: return 8'h7F;
      I_DOW:                return 8'h07;
      I_DATE:               return 8'h3F;
      I_MON:                return 8'h1F;
      default:              return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int idx);
    case (idx)
      I_DOW, I_DATE, I_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] count_q;

  assign tick = (count_q == LAST) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (restart) count_q <= '0;
    else if (tick)    count_q <= '0;
    else              count_q <= count_q + 1'b1;
  end

  // R10: the cycle after a restart never produces an advance
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);
  logic [7:0] year_bin;
  logic       leap;

  assign year_bin = ({4'h0, year[7:4]} * 8'd10) + {4'h0, year[3:0]};
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [6:0] hour_cur,
  output logic [6:0] hour_nx,
  output logic       day_wrap
);
  logic       pm;
  logic [4:0] h12;
  logic [5:0] h24;

  assign pm  = hour_cur[5];
  assign h12 = hour_cur[4:0];
  assign h24 = hour_cur[5:0];

  always_comb begin
    day_wrap = 1'b0;
    if (hour_cur[6]) begin
      if (h12 == 5'h12) begin
        hour_nx = {1'b1, pm, 5'h01};
      end else if (h12 == 5'h11) begin
        hour_nx  = {1'b1, ~pm, 5'h12};
        day_wrap = pm;
      end else if (h12[3:0] == 4'h9) begin
        hour_nx = {1'b1, pm, 5'h10};
      end else begin
        hour_nx = {1'b1, pm, h12[4], h12[3:0] + 4'h1};
      end
    end else begin
      if (h24 == 6'h23) begin
        hour_nx  = 7'h00;
        day_wrap = 1'b1;
      end else if (h24[3:0] == 4'h9) begin
        hour_nx = {1'b0, h24[5:4] + 2'd1, 4'h0};
      end else begin
        hour_nx = {1'b0, h24[5:4], h24[3:0] + 4'h1};
      end
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_d;
  logic       restart, tick;
  logic       c_min, c_hour, c_day, c_mon, c_year, hour_wrap;
  logic [6:0] hour_nx;
  logic [7:0] last_date;

  assign restart = wr_en && (wr_addr < ADDR_W'(NUM_FIELDS));

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick));

  rtc_hour_step u_hour (
    .hour_cur(fld_q[I_HOUR][6:0]), .hour_nx(hour_nx), .day_wrap(hour_wrap));

  rtc_month_days u_mdays (
    .month(fld_q[I_MON]), .year(fld_q[I_YEAR]), .last_date(last_date));

  assign c_min  = (fld_q[I_SEC] == 8'h59);
  assign c_hour = c_min && (fld_q[I_MIN] == 8'h59);
  assign c_day  = c_hour && hour_wrap;
  assign c_mon  = c_day && (fld_q[I_DATE] == last_date);
  assign c_year = c_mon && (fld_q[I_MON] == 8'h12);

  always_comb begin
    fld_d = fld_q;
    fld_d[I_SEC] = c_min ? 8'h00 : bcd_inc(fld_q[I_SEC]);
    if (c_min)  fld_d[I_MIN]  = (fld_q[I_MIN] == 8'h59) ? 8'h00 : bcd_inc(fld_q[I_MIN]);
    if (c_hour) fld_d[I_HOUR] = {1'b0, hour_nx};
    if (c_day) begin
      fld_d[I_DOW]  = (fld_q[I_DOW] == 8'h07) ? 8'h01 : bcd_inc(fld_q[I_DOW]);
      fld_d[I_DATE] = c_mon ? 8'h01 : bcd_inc(fld_q[I_DATE]);
    end
    if (c_mon)  fld_d[I_MON]  = c_year ? 8'h01 : bcd_inc(fld_q[I_MON]);
    if (c_year) fld_d[I_YEAR] = (fld_q[I_YEAR] == 8'h99) ? 8'h00 : bcd_inc(fld_q[I_YEAR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIELDS; i++) fld_q[i] <= field_reset(i);
    end else if (restart) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (wr_addr == ADDR_W'(i)) fld_q[i] <= wr_data & field_mask(i);
    end else if (tick) begin
      fld_q <= fld_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = fld_q[i];
  end

  // R2: seconds stay legal BCD 00..59
  a_r2_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q[I_SEC][3:0] <= 4'h9) && (fld_q[I_SEC] <= 8'h59));
  // R4: a 12-hour value is 01..12 whenever time advances
  a_r4_hour12_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fld_q[I_HOUR][6]) |-> (fld_q[I_HOUR][4:0] != 5'h00) && (fld_q[I_HOUR][4:0] <= 5'h12));
  // R5: day of week is 1..7 whenever time advances
  a_r5_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (fld_q[I_DOW] != 8'h00) && (fld_q[I_DOW] <= 8'h07));
  // R6: the date never exceeds the length of the current month at an advance
  a_r6_date_in_month: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (fld_q[I_DATE] != 8'h00) && (fld_q[I_DATE] <= last_date));
  // R11: no advance and no write means every field holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(fld_q));
endmodule

// File: tb/test_bcd_calendar.sv
`timescale 1ns/100ps
module test_bcd_calendar;
  localparam int TPS = 8;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  int m[7];
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic int b2i(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int mask_of(int a);
    case (a)
      0, 1, 2: return 'h7F;
      3: return 'h07;
      4: return 'h3F;
      5: return 'h1F;
      default: return 'hFF;
    endcase
  endfunction
  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    int v, h, pm;
    bit carry;
    v = b2i(m[0]); if (v < 59) begin m[0] = i2b(v + 1); return; end
    m[0] = 0;
    v = b2i(m[1]); if (v < 59) begin m[1] = i2b(v + 1); return; end
    m[1] = 0;
    carry = 0;
    if (m[2] & 'h40) begin
      h = b2i(m[2] & 'h1F); pm = (m[2] >> 5) & 1;
      if (h == 11) begin h = 12; carry = (pm == 1); pm = 1 - pm; end
      else if (h == 12) h = 1;
      else h = h + 1;
      m[2] = 'h40 | (pm << 5) | i2b(h);
    end else begin
      h = b2i(m[2]);
      if (h == 23) begin m[2] = 0; carry = 1; end else m[2] = i2b(h + 1);
    end
    if (!carry) return;
    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
    v = b2i(m[4]);
    if (v < days_in(b2i(m[5]), b2i(m[6]))) begin m[4] = i2b(v + 1); return; end
    m[4] = 1;
    v = b2i(m[5]); if (v < 12) begin m[5] = i2b(v + 1); return; end
    m[5] = 1;
    m[6] = i2b((b2i(m[6]) + 1) % 100);
  endtask

  task automatic write_field(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 7) m[a] = d & mask_of(a);
  endtask

  task automatic check_one(string tag, int a, int exp);
    rd_addr = 3'(a); #0.2;
    checks++;
    if (rd_data !== 8'(exp)) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, 8'(exp));
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 7; a++) check_one(tag, a, m[a]);
    check_one(tag, 7, 0);
  endtask

  task automatic advance(string tag, int n);
    for (int k = 0; k < n; k++) begin
      repeat (TPS) @(negedge clk);
      model_step();
      check_all(tag);
    end
  endtask

  task automatic set_time(int y, int mo, int d, int dw, int h, int mi, int s);
    write_field(6, y); write_field(5, mo); write_field(4, d); write_field(3, dw);
    write_field(2, h); write_field(1, mi); write_field(0, s);
  endtask

  task automatic run_case(string tag, int y, int mo, int d, int dw, int h, int mi, int s, int n);
    set_time(y, mo, d, dw, h, mi, s);
    check_all(tag);
    advance(tag, n);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, mi, h, mo, y, d, dw, hb, mode12;
    void'($urandom(32'd20240607));
    m = '{0, 0, 0, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R10 / R11: advance exactly TPS cycles after the write, not earlier
    write_field(0, 'h10);
    repeat (TPS - 1) @(negedge clk);
    check_one("R11 hold before advance", 0, 'h10);
    @(negedge clk);
    check_one("R10 advance after write", 0, 'h11);
    repeat (TPS) @(negedge clk);
    check_one("R11 steady cadence", 0, 'h12);

    // R9: masking, unused address reads 0, its write does not restart the count
    write_field(0, 'h85); write_field(1, 'hA7); write_field(2, 'h92);
    write_field(3, 'hF5); write_field(4, 'hC9); write_field(5, 'hE3);
    check_all("R9 masked write");
    write_field(7, 'hFF);
    repeat (TPS - 1) @(negedge clk);
    model_step();
    check_all("R9 address 7 ignored");

    run_case("R2 minute carry", 'h21, 'h05, 'h10, 2, 'h08, 'h58, 'h58, 3);
    run_case("R3 tens bit", 'h21, 'h05, 'h10, 2, 'h19, 'h59, 'h59, 1);
    run_case("R3 midnight", 'h21, 'h05, 'h10, 2, 'h23, 'h59, 'h59, 1);
    run_case("R4 noon", 'h21, 'h05, 'h10, 2, 'h51, 'h59, 'h59, 1);
    run_case("R4 twelve to one", 'h21, 'h05, 'h10, 2, 'h72, 'h59, 'h59, 1);
    run_case("R4 pm midnight", 'h21, 'h05, 'h10, 2, 'h71, 'h59, 'h59, 1);
    run_case("R5 week wrap", 'h21, 'h05, 'h10, 7, 'h23, 'h59, 'h59, 1);
    run_case("R6 april end", 'h21, 'h04, 'h30, 3, 'h23, 'h59, 'h59, 1);
    run_case("R6 january end", 'h21, 'h01, 'h30, 3, 'h23, 'h59, 'h59, 1);
    run_case("R6 january 31", 'h21, 'h01, 'h31, 4, 'h23, 'h59, 'h59, 1);
    run_case("R7 leap 28", 'h24, 'h02, 'h28, 1, 'h23, 'h59, 'h59, 1);
    run_case("R7 leap 29", 'h24, 'h02, 'h29, 1, 'h23, 'h59, 'h59, 1);
    run_case("R7 common 28", 'h23, 'h02, 'h28, 1, 'h23, 'h59, 'h59, 1);
    run_case("R7 year 00", 'h00, 'h02, 'h28, 1, 'h23, 'h59, 'h59, 1);
    run_case("R8 year step", 'h45, 'h12, 'h31, 6, 'h23, 'h59, 'h59, 1);
    run_case("R8 century wrap", 'h99, 'h12, 'h31, 6, 'h71, 'h59, 'h59, 1);

    for (int it = 0; it < 60; it++) begin
      s  = 57 + $urandom % 3;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      mode12 = $urandom % 2;
      if (mode12) begin
        h  = ($urandom % 2) ? 11 + $urandom % 2 : 1 + $urandom % 12;
        hb = 'h40 | (($urandom % 2) << 5) | i2b(h);
      end else begin
        h  = ($urandom % 2) ? 23 : $urandom % 24;
        hb = i2b(h);
      end
      mo = 1 + $urandom % 12;
      y  = $urandom % 100;
      d  = ($urandom % 2) ? days_in(mo, y) : 1 + $urandom % days_in(mo, y);
      dw = 1 + $urandom % 7;
      write_field(6, i2b(y));
      write_field(5, i2b(mo) | ($urandom & ~mask_of(5) & 'hFF));
      write_field(4, i2b(d)  | ($urandom & ~mask_of(4) & 'hFF));
      write_field(3, dw      | ($urandom & ~mask_of(3) & 'hFF));
      write_field(2, hb      | ($urandom & 'h80));
      write_field(1, i2b(mi) | ($urandom & 'h80));
      write_field(0, i2b(s)  | ($urandom & 'h80));
      check_all("R9 random write");
      advance("R2/R3/R4/R6/R7/R8 random run", 1 + $urandom % 4);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule